// File: doc/BRIEF.md
# Predicated Mixed-Sign Saturating Vector Adder

This block is a single-cycle SIMD datapath stage. Each lane of a signed accumulator vector is added to the matching lane of an unsigned source vector. The sum is clamped to the lane's signed range, and a per-lane flag records when the clamp was applied. A two-bit size code splits the vector into lanes of 8, 16, 32 or 64 bits. A mask with one bit per byte chooses which lanes take the new value. Lanes that are not chosen return the accumulator lane untouched.

All four lane widths are computed side by side, and the size code then picks one of them. The chosen result and its flags are held in an output register. They appear one clock edge after the inputs are presented. The vector width is a parameter and must be a multiple of 64 bits.

Top module: `psa_vec_add`

## Requirements
- R1: Size code 0 selects 8-bit lanes, 1 selects 16-bit, 2 selects 32-bit and 3 selects 64-bit (lane width = 8 << code). There are VEC_W / N lanes, and lane e occupies bits [e*N +: N] of every vector.
- R2: In an active lane, the accumulator lane is taken as two's complement and the source lane as unsigned. When their true sum lies within the signed N-bit range, the output lane is that sum.
- R3: In an active lane whose true sum exceeds 2^(N-1)-1, the output lane is 2^(N-1)-1. An active lane's output is never below its accumulator value, because no lower clamp is reachable.
- R4: Saturation flag bit e is 1 exactly when lane e is active and its true sum exceeds 2^(N-1)-1. Flag bits at indices at or above the lane count are 0.
- R5: An inactive lane outputs its accumulator lane unchanged, and its flag is 0. An all-zero mask therefore passes the whole accumulator through.
- R6: Lane e is active when mask bit e*N/8 (the lane's lowest byte) is 1. The mask bits of the lane's other bytes have no effect.
- R7: Inputs sampled at a rising clock edge set the result and flags seen after that edge. The outputs hold until the next edge.
- R8: While the active-low reset is low, the result vector and the flags are 0. The reset is asynchronous.
- R9: An active lane whose source is zero outputs the accumulator unchanged, with its flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_code | input | 2 | Lane width select (8 << code bits) |
| pred_mask | input | VEC_W/8 | One bit per byte; the lane's lowest-byte bit enables it |
| acc_vec | input | VEC_W | Signed accumulator lanes |
| src_vec | input | VEC_W | Unsigned source lanes |
| res_vec | output | VEC_W | Registered merged, saturated result |
| sat_flags | output | VEC_W/8 | Registered per-lane saturation flags, bit e for lane e |

## Verification
The assertions take for granted that every data and control input carries known 0/1 values at each rising edge after reset is released. They also assume that reset is released away from a rising edge. The lane checks hold for all four width banks on any input. The only restriction is that the size code and the mask must be defined, so that the registered selection is meaningful. The stimulus drives every input to zero from time zero. It changes inputs only on falling edges and releases reset on a falling edge. This means each sampled edge sees a settled, fully defined input set.

// File: rtl/psa_pkg.sv
package psa_pkg;

  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_B32 = 2'd2,
    SZ_B64 = 2'd3
  } lane_size_e;

  localparam int NUM_SIZES = 4;
  localparam int MIN_LANE  = 8;

  // lane width in bits for a size code
  function automatic int lane_bits(input logic [1:0] code);
    return MIN_LANE << code;
  endfunction

  // number of lanes a vector of vec_w bits holds at a size code
  function automatic int lane_count(input int vec_w, input logic [1:0] code);
    return vec_w / lane_bits(code);
  endfunction

endpackage

// File: rtl/psa_lane_unit.sv
module psa_lane_unit #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] acc_lane,
  input  logic [LANE_W-1:0] src_lane,
  input  logic              active,
  output logic [LANE_W-1:0] res_lane,
  output logic              sat_hit
);

  // two guard bits: signed max plus unsigned max needs N+2 bits
  localparam int EXT_W = LANE_W + 2;
  localparam logic [LANE_W-1:0] POS_MAX = {1'b0, {(LANE_W-1){1'b1}}};

  function automatic logic [EXT_W-1:0] mixed_add(
    input logic [LANE_W-1:0] s_val,
    input logic [LANE_W-1:0] u_val
  );
    logic [EXT_W-1:0] s_ext, u_ext;
    s_ext = {{2{s_val[LANE_W-1]}}, s_val};
    u_ext = {2'b00, u_val};
    return s_ext + u_ext;
  endfunction

  // positive and beyond the N-bit signed range
  function automatic logic above_max(input logic [EXT_W-1:0] sum);
    return !sum[EXT_W-1] && (sum[EXT_W-2:LANE_W-1] != '0);
  endfunction

  logic [EXT_W-1:0]  wide_sum;
  logic              sum_over;
  logic [LANE_W-1:0] clamped;

  always_comb begin
    wide_sum = mixed_add(acc_lane, src_lane);
    sum_over = above_max(wide_sum);
    clamped  = sum_over ? POS_MAX : wide_sum[LANE_W-1:0];
    res_lane = active ? clamped : acc_lane;
    sat_hit  = active && sum_over;
  end

  // R3: an active lane never goes below its accumulator
  assert_no_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($signed(res_lane) >= $signed(acc_lane)));

  // R3: a flagged lane sits at the signed maximum
  assert_sat_at_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit |-> (res_lane == POS_MAX));

  // R4: flags only come from active lanes
  assert_sat_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit |-> active);

  // R9: zero addend leaves the accumulator
  assert_zero_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && src_lane == '0) |-> (res_lane == acc_lane && !sat_hit));

endmodule

// File: rtl/psa_width_bank.sv
module psa_width_bank #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VEC_W-1:0]   acc_vec,
  input  logic [VEC_W-1:0]   src_vec,
  input  logic [VEC_W/8-1:0] pred_mask,
  output logic [VEC_W-1:0]   res_vec,
  output logic [VEC_W/8-1:0] sat_lanes
);

  localparam int NBYTES    = VEC_W / 8;
  localparam int LANES     = VEC_W / LANE_W;
  localparam int LANE_BYTE = LANE_W / 8;

  logic [LANES-1:0] lane_on;
  logic [LANES-1:0] lane_sat;

  // R6: only the lowest byte's mask bit of each lane enables it
  always_comb begin
    lane_on = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (b % LANE_BYTE == 0) lane_on[b / LANE_BYTE] = pred_mask[b];
    end
  end

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    psa_lane_unit #(.LANE_W(LANE_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_lane (acc_vec[e*LANE_W +: LANE_W]),
      .src_lane (src_vec[e*LANE_W +: LANE_W]),
      .active   (lane_on[e]),
      .res_lane (res_vec[e*LANE_W +: LANE_W]),
      .sat_hit  (lane_sat[e])
    );
  end

  if (LANES < NBYTES) begin : g_pad
    assign sat_lanes = {{(NBYTES-LANES){1'b0}}, lane_sat};
  end else begin : g_full
    assign sat_lanes = lane_sat;
  end

endmodule

// File: rtl/psa_vec_add.sv
module psa_vec_add
  import psa_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         size_code,
  input  logic [VEC_W/8-1:0] pred_mask,
  input  logic [VEC_W-1:0]   acc_vec,
  input  logic [VEC_W-1:0]   src_vec,
  output logic [VEC_W-1:0]   res_vec,
  output logic [VEC_W/8-1:0] sat_flags
);

  localparam int NBYTES = VEC_W / 8;

  logic [VEC_W-1:0]  bank_res [NUM_SIZES];
  logic [NBYTES-1:0] bank_sat [NUM_SIZES];
  logic [VEC_W-1:0]  sel_res;
  logic [NBYTES-1:0] sel_sat;

  initial begin
    if (VEC_W % 64 != 0 || VEC_W < 64)
      $error("psa_vec_add: VEC_W must be a positive multiple of 64");
  end

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_bank
    psa_width_bank #(.VEC_W(VEC_W), .LANE_W(MIN_LANE << g)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_vec   (acc_vec),
      .src_vec   (src_vec),
      .pred_mask (pred_mask),
      .res_vec   (bank_res[g]),
      .sat_lanes (bank_sat[g])
    );
  end

  // R1: the size code picks one bank
  always_comb begin
    sel_res = bank_res[size_code];
    sel_sat = bank_sat[size_code];
  end

  // R7, R8: single output register with async clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vec   <= '0;
      sat_flags <= '0;
    end else begin
      res_vec   <= sel_res;
      sat_flags <= sel_sat;
    end
  end

  // R8: outputs are clear on the first edge after reset release
  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (res_vec == '0 && sat_flags == '0));

  // R5: all-zero mask passes the accumulator through a cycle later
  assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_mask == '0) |=> (res_vec == $past(acc_vec) && sat_flags == '0));

  // R4: no more flags than lanes at the sampled size
  assert_flag_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(sat_flags) <= lane_count(VEC_W, $past(size_code))));

endmodule

// File: tb/sim_psa_vec_add.sv
module sim_psa_vec_add;

  localparam int VW = 128;
  localparam int NB = VW / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    sz;
  logic [NB-1:0] pm;
  logic [VW-1:0] acc, src;
  logic [VW-1:0] res;
  logic [NB-1:0] sat;

  int n_chk = 0;
  int n_bad = 0;
  logic [VW-1:0] prev_res;
  logic [NB-1:0] prev_sat;

  always #5 clk = ~clk;

  psa_vec_add #(.VEC_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .size_code(sz), .pred_mask(pm),
    .acc_vec(acc), .src_vec(src), .res_vec(res), .sat_flags(sat)
  );

  task automatic check_v(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s res got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_f(input string req, input logic [NB-1:0] got, input logic [NB-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s flags got=%h exp=%h", req, got, exp);
    end
  endtask

  // replicate the low N bits of pat into every lane
  function automatic logic [VW-1:0] fill(input int code, input logic [63:0] pat);
    int n = 8 << code;
    logic [VW-1:0] v;
    for (int i = 0; i < VW; i++) v[i] = pat[i % n];
    return v;
  endfunction

  // mask with only each lane's lowest-byte bit set
  function automatic logic [NB-1:0] low_mask(input int code);
    int bpl = 1 << code;
    logic [NB-1:0] m;
    for (int b = 0; b < NB; b++) m[b] = (b % bpl == 0);
    return m;
  endfunction

  // arithmetic reference: signed acc + unsigned src at 66 bits
  task automatic model(input int code, input logic [NB-1:0] p,
                       input logic [VW-1:0] a_v, input logic [VW-1:0] s_v,
                       output logic [VW-1:0] r, output logic [NB-1:0] f);
    int n = 8 << code;
    logic signed [65:0] a, s, t, mx;
    r = '0;
    f = '0;
    mx = (66'sd1 <<< (n - 1)) - 66'sd1;
    for (int e = 0; e < VW / n; e++) begin
      for (int b = 0; b < 66; b++) begin
        a[b] = (b < n) ? a_v[e*n + b] : a_v[e*n + n - 1];
        s[b] = (b < n) ? s_v[e*n + b] : 1'b0;
      end
      t = a + s;
      if (p[e*n/8]) begin
        if (t > mx) begin
          t = mx;
          f[e] = 1'b1;
        end
      end else begin
        t = a;
      end
      for (int b = 0; b < n; b++) r[e*n + b] = t[b];
    end
  endtask

  // drive at a falling edge, check hold (R7), then check the result after the edge
  task automatic run(input string req, input int code, input logic [NB-1:0] p,
                     input logic [VW-1:0] a_v, input logic [VW-1:0] s_v);
    logic [VW-1:0] er;
    logic [NB-1:0] ef;
    sz = code[1:0];
    pm = p;
    acc = a_v;
    src = s_v;
    #1;
    check_v("R7 hold", res, prev_res);
    check_f("R7 hold", sat, prev_sat);
    @(posedge clk);
    @(negedge clk);
    model(code, p, a_v, s_v, er, ef);
    check_v(req, res, er);
    check_f(req, sat, ef);
    prev_res = er;
    prev_sat = ef;
  endtask

  function automatic logic [VW-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sz = '0;
    pm = '0;
    acc = '0;
    src = '0;
    repeat (3) @(negedge clk);
    check_v("R8 reset", res, '0);
    check_f("R8 reset", sat, '0);
    // inputs change under reset: outputs stay clear (R8)
    sz = 2'd0;
    pm = '1;
    acc = fill(0, 64'h7f);
    src = '1;
    @(negedge clk);
    check_v("R8 reset hold", res, '0);
    check_f("R8 reset hold", sat, '0);
    rst_n = 1'b1;
    prev_res = '0;
    prev_sat = '0;
    acc = '0;
    src = '0;
    pm = '0;
    @(negedge clk);

    for (int code = 0; code < 4; code++) begin
      int n = 8 << code;
      logic [63:0] pmax = (64'd1 << (n - 1)) - 64'd1;
      logic [63:0] pmin = 64'd1 << (n - 1);
      // R3, R4: signed max + unsigned max saturates every lane
      run("R3 max+umax", code, '1, fill(code, pmax), '1);
      // R2: signed min + unsigned max lands exactly on max, no flag
      run("R2 min+umax", code, '1, fill(code, pmin), '1);
      // R2: -1 + 1 = 0
      run("R2 neg1+1", code, '1, '1, fill(code, 64'd1));
      // R9: zero addend
      run("R9 zero src", code, '1, rnd_vec(), '0);
      // R5: all-zero mask
      run("R5 no pred", code, '0, rnd_vec(), '1);
      // R6: only non-lowest byte bits set -> all lanes inactive
      run("R6 upper bits", code, ~low_mask(code), fill(code, pmax), '1);
      // R6: only lowest byte bits set -> all lanes active
      run("R6 low bits", code, low_mask(code), fill(code, pmax), '1);
      // R1, R2, R3, R4, R5: random data and masks
      for (int k = 0; k < 150; k++) begin
        run("R1 random", code, NB'($urandom), rnd_vec(), rnd_vec());
      end
      // R3: near-max accumulators with small and large addends
      for (int k = 0; k < 20; k++) begin
        run("R3 near max", code, NB'($urandom), fill(code, pmax - 64'($urandom % 4)),
            fill(code, 64'($urandom % 8)));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule